// File: doc/BRIEF.md
# Dual-Channel Host I/O Address Decoder

This block decides which of two mailbox channels, if any, a host I/O cycle belongs to, and which register inside that channel the cycle touches. Each channel owns a 16-bit base address. A host strobe carries a 16-bit address, a read/write indicator and a write byte. The incoming address is compared with every enabled channel's base on all bits except bit 2. A hit writes the input data register of that channel, or returns either the output data register or the status register. On writes, address bit 2 also sets or clears a per-channel flag that tells the local processor whether the byte was a command or plain data.

The local processor reaches the block through a small register file. It sets channel enables and a window select bit. The window select steers one shared pair of high/low staging locations onto one channel's base address. The processor fills both output data registers and both status registers, and reads back the input data registers and the command/data flags. A base address cannot be altered while its channel is enabled. Staging writes aimed at an enabled channel are dropped.

Top module: `hio_dual_decoder`

## Requirements
- R1: After reset, channel 0's base is 0x0060, channel 1's base is 0x0062, both channels are disabled, the window select is 0, and every data register, status register and flag is 0.
- R2: A host cycle hits a channel only when address bits 15..3 and 1..0 equal the same bits of that channel's base; address bit 2 is not compared, and a cycle that hits no channel changes nothing and returns 0.
- R3: A host write hit with address bit 2 = 0 loads the write byte into that channel's input data register and clears its command/data flag to 0.
- R4: A host write hit with address bit 2 = 1 loads the write byte into that channel's input data register and sets its command/data flag to 1.
- R5: A host read hit returns the channel's output data register when address bit 2 = 0 and its status register when bit 2 = 1, in the same cycle as the strobe; the read data is 0 when there is no read strobe or no hit.
- R6: Local writes to the staging high location (local address 0) and low location (local address 1) update bits 15..8 and 7..0 of channel 0's base when the window select (control bit 0) is 0, and of channel 1's base when it is 1; reading the same locations returns the selected base's bytes.
- R7: A staging write aimed at a channel whose enable is set leaves that channel's base unchanged.
- R8: A channel whose enable is clear (control bit 1 for channel 0, bit 2 for channel 1) never hits, and host cycles leave its input register and flag unchanged.
- R9: When both channels match one address, only channel 0 is selected, for reads and for writes.
- R10: Local address map: 2 control (read/write), 3 and 4 channel 0 output data and status, 5 and 6 channel 1 output data and status (write, read back), 8 and 9 channel 0 and channel 1 input data (read), 10 flags (bit 0 channel 0, bit 1 channel 1, read); local reads are combinational and local writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hst_stb | input | 1 | Host cycle strobe, one clock per cycle |
| hst_wr | input | 1 | 1 for a host write, 0 for a host read |
| hst_addr | input | 16 | Host I/O address |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read data, 0 when no read hit |
| loc_we | input | 1 | Local register write strobe |
| loc_addr | input | 4 | Local register index |
| loc_wdata | input | 8 | Local write byte |
| loc_rdata | output | 8 | Local read data for loc_addr |

## Verification
Host read data is combinational. It is due in the same cycle as the strobe, so the bench drives the strobe just after a falling edge and samples two nanoseconds later, before the next rising edge. Host writes, staging writes and control writes land at the rising edge that follows the strobe. Each of their effects is therefore read back through the combinational local port after the next falling edge, once the strobe has dropped. Checks made in that order cannot confuse a register's old value with its new one.

// File: rtl/hio_pkg.sv
package hio_pkg;

  localparam int unsigned NCH    = 2;
  localparam int unsigned SEL_W  = 1;
  localparam int unsigned LOC_AW = 4;

  // control register bit positions
  localparam int unsigned CTRL_SEL    = 0;
  localparam int unsigned CTRL_EN_LSB = 1;

  typedef enum logic [LOC_AW-1:0] {
    LA_WIN_HI = 4'd0,
    LA_WIN_LO = 4'd1,
    LA_CTRL   = 4'd2,
    LA_OUT0   = 4'd3,
    LA_STAT0  = 4'd4,
    LA_IN0    = 4'd8,
    LA_FLAGS  = 4'd10
  } loc_reg_e;

  function automatic logic [LOC_AW-1:0] out_idx(int unsigned c);
    return LOC_AW'(LA_OUT0) + LOC_AW'(2 * c);
  endfunction

  function automatic logic [LOC_AW-1:0] stat_idx(int unsigned c);
    return LOC_AW'(LA_STAT0) + LOC_AW'(2 * c);
  endfunction

  function automatic logic [LOC_AW-1:0] in_idx(int unsigned c);
    return LOC_AW'(LA_IN0) + LOC_AW'(c);
  endfunction

endpackage

// File: rtl/hio_rst_sync.sv
module hio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/hio_cfg_regs.sv
module hio_cfg_regs
  import hio_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [NCH-1:0][ADDR_W-1:0] BASE_RST = {16'h0062, 16'h0060}
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         loc_we,
  input  logic [LOC_AW-1:0]            loc_addr,
  input  logic [DATA_W-1:0]            loc_wdata,
  output logic [NCH-1:0][ADDR_W-1:0]   base,
  output logic [NCH-1:0]               en,
  output logic [SEL_W-1:0]             sel
);

  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic             ctrl_we;
  logic             hi_we;
  logic             lo_we;
  logic [NCH-1:0]   en_q, en_d;
  logic [SEL_W-1:0] sel_q, sel_d;

  assign ctrl_we = loc_we && (loc_addr == LA_CTRL);
  assign hi_we   = loc_we && (loc_addr == LA_WIN_HI);
  assign lo_we   = loc_we && (loc_addr == LA_WIN_LO);

  always_comb begin
    sel_d = sel_q;
    en_d  = en_q;
    if (ctrl_we) begin
      sel_d = loc_wdata[CTRL_SEL +: SEL_W];
      en_d  = loc_wdata[CTRL_EN_LSB +: NCH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= '0;
    end else if (ctrl_we) begin
      sel_q <= sel_d;
      en_q  <= en_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_base
    logic              aimed;
    logic [ADDR_W-1:0] b_q, b_d;

    // staging window reaches this base only while its channel is idle
    assign aimed = (sel_q == SEL_W'(c)) && !en_q[c];

    always_comb begin
      b_d = b_q;
      if (hi_we && aimed) begin
        b_d[ADDR_W-1:DATA_W] = loc_wdata[HI_W-1:0];
      end
      if (lo_we && aimed) begin
        b_d[DATA_W-1:0] = loc_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_q <= BASE_RST[c];
      end else if ((hi_we || lo_we) && aimed) begin
        b_q <= b_d;
      end
    end

    assign base[c] = b_q;
  end

  assign en  = en_q;
  assign sel = sel_q;

endmodule

// File: rtl/hio_addr_match.sv
module hio_addr_match
  import hio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned STEER_BIT = 2
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NCH-1:0][ADDR_W-1:0] base,
  input  logic [NCH-1:0]             en,
  output logic [NCH-1:0]             match,
  output logic [NCH-1:0]             grant
);

  localparam logic [ADDR_W-1:0] CMP_MASK = ~(ADDR_W'(1) << STEER_BIT);

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    assign match[c] = en[c] && (((addr ^ base[c]) & CMP_MASK) == '0);
  end

  // lowest channel index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int c = 0; c < NCH; c++) begin
      grant[c] = match[c] && !taken;
      taken    = taken || match[c];
    end
  end

endmodule

// File: rtl/hio_chan_regs.sv
module hio_chan_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_we,
  input  logic              hst_cmd,
  input  logic [DATA_W-1:0] hst_wdata,
  input  logic              out_we,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] in_q,
  output logic              cd_q,
  output logic [DATA_W-1:0] out_q,
  output logic [DATA_W-1:0] stat_q
);

  logic [DATA_W-1:0] in_d, out_d, stat_d;
  logic              cd_d;

  always_comb begin
    in_d   = in_q;
    cd_d   = cd_q;
    out_d  = out_q;
    stat_d = stat_q;
    if (hst_we) begin
      in_d = hst_wdata;
      cd_d = hst_cmd;
    end
    if (out_we) begin
      out_d = loc_wdata;
    end
    if (stat_we) begin
      stat_d = loc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= '0;
      cd_q <= 1'b0;
    end else if (hst_we) begin
      in_q <= in_d;
      cd_q <= cd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_we) begin
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_we) begin
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/hio_dual_decoder.sv
module hio_dual_decoder
  import hio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STEER_BIT = 2,
  parameter logic [NCH-1:0][ADDR_W-1:0] BASE_RST = {16'h0062, 16'h0060}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_stb,
  input  logic              hst_wr,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  input  logic              loc_we,
  input  logic [LOC_AW-1:0] loc_addr,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata
);

  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic                         rst_sync_n;
  logic [NCH-1:0][ADDR_W-1:0]   base;
  logic [NCH-1:0]               en;
  logic [SEL_W-1:0]             sel;
  logic [NCH-1:0]               match;
  logic [NCH-1:0]               grant;
  logic [NCH-1:0][DATA_W-1:0]   in_q;
  logic [NCH-1:0][DATA_W-1:0]   out_q;
  logic [NCH-1:0][DATA_W-1:0]   stat_q;
  logic [NCH-1:0]               cd_q;

  hio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hio_cfg_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BASE_RST (BASE_RST)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .loc_we    (loc_we),
    .loc_addr  (loc_addr),
    .loc_wdata (loc_wdata),
    .base      (base),
    .en        (en),
    .sel       (sel)
  );

  hio_addr_match #(
    .ADDR_W    (ADDR_W),
    .STEER_BIT (STEER_BIT)
  ) u_match (
    .addr  (hst_addr),
    .base  (base),
    .en    (en),
    .match (match),
    .grant (grant)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic hst_we_c;
    logic out_we_c;
    logic stat_we_c;

    assign hst_we_c  = hst_stb && hst_wr && grant[c];
    assign out_we_c  = loc_we && (loc_addr == out_idx(c));
    assign stat_we_c = loc_we && (loc_addr == stat_idx(c));

    hio_chan_regs #(.DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .hst_we    (hst_we_c),
      .hst_cmd   (hst_addr[STEER_BIT]),
      .hst_wdata (hst_wdata),
      .out_we    (out_we_c),
      .stat_we   (stat_we_c),
      .loc_wdata (loc_wdata),
      .in_q      (in_q[c]),
      .cd_q      (cd_q[c]),
      .out_q     (out_q[c]),
      .stat_q    (stat_q[c])
    );
  end

  // host read path: steer bit picks status over output data
  always_comb begin
    hst_rdata = '0;
    if (hst_stb && !hst_wr) begin
      for (int c = 0; c < NCH; c++) begin
        if (grant[c]) begin
          hst_rdata = hst_addr[STEER_BIT] ? stat_q[c] : out_q[c];
        end
      end
    end
  end

  // local read path
  always_comb begin
    loc_rdata = '0;
    case (loc_addr)
      LA_WIN_HI: loc_rdata[HI_W-1:0] = base[sel][ADDR_W-1:DATA_W];
      LA_WIN_LO: loc_rdata = base[sel][DATA_W-1:0];
      LA_CTRL: begin
        loc_rdata[CTRL_SEL +: SEL_W]  = sel;
        loc_rdata[CTRL_EN_LSB +: NCH] = en;
      end
      LA_FLAGS: loc_rdata[NCH-1:0] = cd_q;
      default: ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (loc_addr == out_idx(c))  loc_rdata = out_q[c];
      if (loc_addr == stat_idx(c)) loc_rdata = stat_q[c];
      if (loc_addr == in_idx(c))   loc_rdata = in_q[c];
    end
  end

endmodule

// File: rtl/hio_dual_decoder_chk.sv
module hio_dual_decoder_chk
  import hio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STEER_BIT = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       hst_stb,
  input logic                       hst_wr,
  input logic [ADDR_W-1:0]          hst_addr,
  input logic [DATA_W-1:0]          hst_wdata,
  input logic [DATA_W-1:0]          hst_rdata,
  input logic [NCH-1:0]             match,
  input logic [NCH-1:0]             grant,
  input logic [NCH-1:0]             en,
  input logic [NCH-1:0][ADDR_W-1:0] base,
  input logic [NCH-1:0][DATA_W-1:0] in_q,
  input logic [NCH-1:0][DATA_W-1:0] out_q,
  input logic [NCH-1:0][DATA_W-1:0] stat_q,
  input logic [NCH-1:0]             cd_q
);

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hst_stb || hst_wr) |-> (hst_rdata == '0));

  p_ch0_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_stb && !hst_wr && match[0] && !hst_addr[STEER_BIT]) |-> (hst_rdata == out_q[0]));

  p_ch0_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_stb && !hst_wr && match[0] && hst_addr[STEER_BIT]) |-> (hst_rdata == stat_q[0]));

  p_grant_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_cmd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_stb && hst_wr && grant[0] && !hst_addr[STEER_BIT])
      |=> (!cd_q[0] && (in_q[0] == $past(hst_wdata))));

  p_cmd_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_stb && hst_wr && grant[1] && hst_addr[STEER_BIT])
      |=> (cd_q[1] && (in_q[1] == $past(hst_wdata))));

  p_base0_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en[0] |=> $stable(base[0]));

  p_base1_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en[1] |=> $stable(base[1]));

  p_dis_nohit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en[0] |-> !match[0]);

  p_dis_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en[1] |=> ($stable(in_q[1]) && $stable(cd_q[1])));

endmodule

bind hio_dual_decoder hio_dual_decoder_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .STEER_BIT (STEER_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .hst_stb   (hst_stb),
  .hst_wr    (hst_wr),
  .hst_addr  (hst_addr),
  .hst_wdata (hst_wdata),
  .hst_rdata (hst_rdata),
  .match     (match),
  .grant     (grant),
  .en        (en),
  .base      (base),
  .in_q      (in_q),
  .out_q     (out_q),
  .stat_q    (stat_q),
  .cd_q      (cd_q)
);

// File: tb/tb_hio_dual_decoder.sv
`timescale 1ns/1ps
module tb_hio_dual_decoder;

  logic       clk;
  logic       rst_n;
  logic       hst_stb;
  logic       hst_wr;
  logic [15:0] hst_addr;
  logic [7:0] hst_wdata;
  logic [7:0] hst_rdata;
  logic       loc_we;
  logic [3:0] loc_addr;
  logic [7:0] loc_wdata;
  logic [7:0] loc_rdata;

  int checks;
  int fails;
  bit done;

  hio_dual_decoder dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_stb   (hst_stb),
    .hst_wr    (hst_wr),
    .hst_addr  (hst_addr),
    .hst_wdata (hst_wdata),
    .hst_rdata (hst_rdata),
    .loc_we    (loc_we),
    .loc_addr  (loc_addr),
    .loc_wdata (loc_wdata),
    .loc_rdata (loc_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {wr, addr, wdata, exp_a, exp_b, exp_c}
  // read:  exp_a = host read data
  // write: exp_a = ch0 input, exp_b = ch1 input, exp_c = flags
  localparam int NVEC = 13;
  localparam logic [48:0] VEC [NVEC] = '{
    {1'b0, 16'h0060, 8'h00, 8'hA1, 8'h00, 8'h00},
    {1'b0, 16'h0064, 8'h00, 8'hB1, 8'h00, 8'h00},
    {1'b0, 16'h0062, 8'h00, 8'hA2, 8'h00, 8'h00},
    {1'b0, 16'h0066, 8'h00, 8'hB2, 8'h00, 8'h00},
    {1'b0, 16'h0061, 8'h00, 8'h00, 8'h00, 8'h00},
    {1'b0, 16'h0068, 8'h00, 8'h00, 8'h00, 8'h00},
    {1'b0, 16'h8060, 8'h00, 8'h00, 8'h00, 8'h00},
    {1'b1, 16'h0060, 8'h11, 8'h11, 8'h00, 8'h00},
    {1'b1, 16'h0064, 8'h22, 8'h22, 8'h00, 8'h01},
    {1'b1, 16'h0066, 8'h33, 8'h22, 8'h33, 8'h03},
    {1'b1, 16'h0062, 8'h44, 8'h22, 8'h44, 8'h01},
    {1'b1, 16'h0060, 8'h55, 8'h55, 8'h44, 8'h00},
    {1'b1, 16'h0070, 8'h99, 8'h55, 8'h44, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic loc_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    loc_we    = 1'b1;
    loc_addr  = a;
    loc_wdata = d;
    @(negedge clk);
    loc_we    = 1'b0;
  endtask

  task automatic loc_read(input logic [3:0] a, output logic [7:0] d);
    loc_addr = a;
    #1;
    d = loc_rdata;
  endtask

  task automatic host_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_stb   = 1'b1;
    hst_wr    = 1'b1;
    hst_addr  = a;
    hst_wdata = d;
    @(negedge clk);
    hst_stb   = 1'b0;
    hst_wr    = 1'b0;
  endtask

  task automatic host_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    hst_stb  = 1'b1;
    hst_wr   = 1'b0;
    hst_addr = a;
    #2;
    d = hst_rdata;
    @(negedge clk);
    hst_stb  = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  r;
    logic [48:0] v;
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; hst_stb = 1'b0; hst_wr = 1'b0; hst_addr = '0; hst_wdata = '0;
    loc_we = 1'b0; loc_addr = '0; loc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    loc_read(4'd1, r);  chk("R1 ch0 base low", r, 8'h60);
    loc_read(4'd0, r);  chk("R1 ch0 base high", r, 8'h00);
    loc_read(4'd2, r);  chk("R1 control", r, 8'h00);
    loc_read(4'd10, r); chk("R1 flags", r, 8'h00);
    loc_read(4'd8, r);  chk("R1 ch0 input", r, 8'h00);
    loc_read(4'd6, r);  chk("R1 ch1 status", r, 8'h00);
    loc_write(4'd2, 8'h01);
    loc_read(4'd1, r);  chk("R1 ch1 base low", r, 8'h62);
    loc_read(4'd0, r);  chk("R1 ch1 base high", r, 8'h00);
    loc_write(4'd2, 8'h00);

    // R8 disabled channels ignore host cycles
    host_read(16'h0060, r);  chk("R8 read while disabled", r, 8'h00);
    host_write(16'h0064, 8'h5A);
    loc_read(4'd8, r);  chk("R8 ch0 input untouched", r, 8'h00);
    loc_read(4'd10, r); chk("R8 flags untouched", r, 8'h00);

    // R10 local side setup
    loc_write(4'd3, 8'hA1);
    loc_write(4'd4, 8'hB1);
    loc_write(4'd5, 8'hA2);
    loc_write(4'd6, 8'hB2);
    loc_write(4'd2, 8'h06);
    loc_read(4'd3, r); chk("R10 ch0 output readback", r, 8'hA1);
    loc_read(4'd6, r); chk("R10 ch1 status readback", r, 8'hB2);
    loc_read(4'd2, r); chk("R10 control readback", r, 8'h06);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      if (!v[48]) begin
        host_read(v[47:32], r);
        chk($sformatf("R5 R2 vector %0d host read", i), r, v[23:16]);
      end else begin
        host_write(v[47:32], v[31:24]);
        loc_read(4'd8, r);  chk($sformatf("R3 R4 vector %0d ch0 input", i), r, v[23:16]);
        loc_read(4'd9, r);  chk($sformatf("R3 R4 vector %0d ch1 input", i), r, v[15:8]);
        loc_read(4'd10, r); chk($sformatf("R3 R4 vector %0d flags", i), r, v[7:0]);
      end
    end

    // R7 staging write to an enabled channel is dropped
    loc_write(4'd1, 8'h80);
    loc_read(4'd1, r);  chk("R7 base low kept", r, 8'h60);
    host_read(16'h0060, r); chk("R7 ch0 still at old base", r, 8'hA1);

    // R6 window steered to channel 1 while it is disabled
    loc_write(4'd2, 8'h03);
    loc_write(4'd0, 8'h12);
    loc_write(4'd1, 8'h40);
    loc_read(4'd0, r); chk("R6 ch1 base high", r, 8'h12);
    loc_read(4'd1, r); chk("R6 ch1 base low", r, 8'h40);
    loc_write(4'd2, 8'h07);
    host_read(16'h1240, r); chk("R6 ch1 new base output", r, 8'hA2);
    host_read(16'h1244, r); chk("R6 ch1 new base status", r, 8'hB2);
    host_read(16'h0062, r); chk("R6 ch1 old base gone", r, 8'h00);

    // R9 both channels on the same base
    loc_write(4'd2, 8'h03);
    loc_write(4'd0, 8'h00);
    loc_write(4'd1, 8'h60);
    loc_write(4'd2, 8'h07);
    host_read(16'h0060, r); chk("R9 overlap read picks ch0", r, 8'hA1);
    host_read(16'h0064, r); chk("R9 overlap status picks ch0", r, 8'hB1);
    host_write(16'h0064, 8'h77);
    loc_read(4'd8, r);  chk("R9 overlap write ch0 input", r, 8'h77);
    loc_read(4'd9, r);  chk("R9 overlap write ch1 untouched", r, 8'h44);
    loc_read(4'd10, r); chk("R9 overlap write flags", r, 8'h01);

    // R8 channel 0 disabled, channel 1 takes the shared address
    loc_write(4'd2, 8'h05);
    host_read(16'h0060, r); chk("R8 ch0 off, ch1 answers", r, 8'hA2);
    host_write(16'h0060, 8'h88);
    loc_read(4'd8, r);  chk("R8 ch0 input untouched", r, 8'h77);
    loc_read(4'd9, r);  chk("R8 ch1 input written", r, 8'h88);
    loc_read(4'd10, r); chk("R8 flags after ch1 data", r, 8'h01);
    loc_write(4'd2, 8'h00);
    host_read(16'h0064, r); chk("R8 all disabled read", r, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule